// File: doc/BRIEF.md
# DRAM Refresh Scheduler

The scheduler keeps every row of a DRAM device inside its retention window. A time base counts out a refresh interval (retention time divided by the row count, both given in nanoseconds together with the clock period). A window of retention length is built from a whole number of such intervals. A backlog counter records how many row refreshes are owed. A small engine raises a request to the access arbiter, waits for the grant, and then holds a busy flag for a fixed number of cycles. That busy period stands in for the read-and-write-back that restores a row. During busy no normal access may begin. The row address advances after each completed refresh.

Two schedules share the same row counter. In distributed mode one refresh becomes due at the end of every interval. In burst mode the whole array becomes due at once at the start of each window, and the refreshes then run back to back. Nothing further becomes due until the next window. The mode input is sampled only on a window boundary. The backlog in distributed mode is capped, so a long stall of the arbiter costs at most a bounded catch-up burst.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and until the first refresh is due, `ref_req_o` and `ref_busy_o` are 0 and `ref_row_o` is 0.
- R2: In distributed mode, with the grant held high, `ref_busy_o` rises once per interval: successive rising edges are exactly INT_CYC = (RETENTION_NS/CLK_NS)/ROWS cycles apart.
- R3: In the cycle after a cycle with `ref_req_o` and `ref_gnt_i` both high, `ref_req_o` is 0 and `ref_busy_o` is 1. Busy stays high for exactly BUSY_CYC = ceil(REFRESH_NS/CLK_NS) cycles.
- R4: Once `ref_req_o` is raised it stays high on every cycle until a grant is seen; a withheld grant never loses a due refresh.
- R5: In distributed mode, refreshes that fall due while the grant is withheld are counted up to MAX_OWED. When the grant returns, exactly that many refreshes run back to back, each one request cycle plus BUSY_CYC busy cycles. Refreshes due beyond the cap are discarded.
- R6: Each completed refresh advances `ref_row_o` by one, and the row after ROWS-1 is 0.
- R7: With `burst_mode_i` = 1 at a window boundary, the next window starts with ROWS back-to-back refreshes. No further refresh occurs in that window.
- R8: `burst_mode_i` (1 = burst, 0 = distributed) takes effect only at the end of the window in progress. A change in mid-window leaves that window's schedule unchanged.
- R9: `ref_req_o` and `ref_busy_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| burst_mode_i | input | 1 | Requested schedule for the next window: 1 burst, 0 distributed |
| ref_gnt_i | input | 1 | Arbiter grant for the pending refresh request |
| ref_req_o | output | 1 | Refresh request to the arbiter, held until granted |
| ref_busy_o | output | 1 | High while a row refresh occupies the device |
| ref_row_o | output | $clog2(ROWS) | Row being refreshed (valid while busy) |

## Verification
The hardest state to reach from the ports is a saturated backlog followed by a catch-up. The bench withholds the grant for ten intervals and then grants again on the cycle after an interval boundary. From that point the number of busy pulses follows exactly from the cap and the intervals that follow: three in the first 19 cycles and five in the first 60. Without a cap there would be ten. Mode deferral is reached by lining the stimulus up with a cycle count kept since reset. The mode input is changed in mid-window, and the busy pulses are then counted on either side of the boundary.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_REQ  = 2'd1,
    RS_BUSY = 2'd2
  } rfsh_state_e;
endpackage

// File: rtl/refresh_timebase.sv
`timescale 1ns/1ps
module refresh_timebase #(
  parameter int INT_CYC = 781,
  parameter int ROWS    = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic win_start_o
);
  localparam int ICW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;
  localparam int SW  = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ICW-1:0] ic_q, ic_n;
  logic [SW-1:0]  slot_q, slot_n;
  logic           ic_last, slot_last;

  assign ic_last     = (ic_q == ICW'(INT_CYC - 1));
  assign slot_last   = (slot_q == SW'(ROWS - 1));
  assign tick_o      = ic_last;
  assign win_start_o = ic_last && slot_last;

  always_comb begin
    ic_n   = ic_last ? '0 : ic_q + 1'b1;
    slot_n = slot_q;
    if (ic_last) slot_n = slot_last ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= '0;
      slot_q <= '0;
    end else begin
      ic_q   <= ic_n;
      slot_q <= slot_n;
    end
  end
endmodule

// File: rtl/refresh_backlog.sv
`timescale 1ns/1ps
module refresh_backlog #(
  parameter int ROWS     = 4096,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic win_start_i,
  input  logic burst_req_i,
  input  logic take_i,
  output logic pending_o
);
  localparam int OW = $clog2(ROWS + 1);

  logic [OW-1:0] owed_q, owed_n;
  logic          mode_q, mode_n;

  always_comb begin
    mode_n = mode_q;
    if (win_start_i) mode_n = burst_req_i;
  end

  always_comb begin
    if (win_start_i && burst_req_i) begin
      owed_n = OW'(ROWS);
    end else begin
      owed_n = owed_q;
      if (take_i && owed_n != '0) owed_n = owed_n - 1'b1;
      if (tick_i && !mode_q && owed_n < OW'(MAX_OWED)) owed_n = owed_n + 1'b1;
    end
  end

  assign pending_o = (owed_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      mode_q <= 1'b0;
    end else begin
      owed_q <= owed_n;
      if (win_start_i) mode_q <= mode_n;
    end
  end

  AST_MODE_ONLY_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start_i |=> $stable(mode_q)); // R8

  AST_OWED_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !win_start_i && owed_q <= OW'(MAX_OWED)) |=> owed_q <= OW'(MAX_OWED)); // R5
endmodule

// File: rtl/refresh_engine.sv
`timescale 1ns/1ps
module refresh_engine
  import dram_refresh_pkg::*;
#(
  parameter int ROWS     = 4096,
  parameter int BUSY_CYC = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   pending_i,
  input  logic                                   gnt_i,
  output logic                                   req_o,
  output logic                                   busy_o,
  output logic                                   take_o,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row_o
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int BW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

  rfsh_state_e   state_q, state_n;
  logic [BW-1:0] bcnt_q, bcnt_n;
  logic [RW-1:0] row_q, row_n;

  always_comb begin
    state_n = state_q;
    bcnt_n  = bcnt_q;
    row_n   = row_q;
    unique case (state_q)
      RS_IDLE: if (pending_i) state_n = RS_REQ;
      RS_REQ: begin
        if (gnt_i) begin
          state_n = RS_BUSY;
          bcnt_n  = BW'(BUSY_CYC - 1);
        end
      end
      RS_BUSY: begin
        if (bcnt_q == '0) begin
          row_n   = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
          state_n = pending_i ? RS_REQ : RS_IDLE;
        end else begin
          bcnt_n = bcnt_q - 1'b1;
        end
      end
      default: state_n = RS_IDLE;
    endcase
  end

  assign req_o  = (state_q == RS_REQ);
  assign busy_o = (state_q == RS_BUSY);
  assign take_o = req_o && gnt_i;
  assign row_o  = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      bcnt_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_n;
      bcnt_q  <= bcnt_n;
      row_q   <= row_n;
    end
  end

  AST_REQ_HELD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o); // R4

  AST_GNT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> (busy_o && !req_o)); // R3

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && busy_o)); // R9

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(row_q) != RW'(ROWS - 1)) |-> row_q == $past(row_q) + 1'b1); // R6

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(row_q) == RW'(ROWS - 1)) |-> row_q == '0); // R6
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int ROWS         = 4096,
  parameter int CLK_NS       = 20,
  parameter int RETENTION_NS = 64_000_000,
  parameter int REFRESH_NS   = 100,
  parameter int MAX_OWED     = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   burst_mode_i,
  input  logic                                   ref_gnt_i,
  output logic                                   ref_req_o,
  output logic                                   ref_busy_o,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] ref_row_o
);
  localparam int RET_CYC  = RETENTION_NS / CLK_NS;
  localparam int INT_CYC  = (RET_CYC / ROWS > 0) ? RET_CYC / ROWS : 1;
  localparam int BUSY_CYC = (REFRESH_NS + CLK_NS - 1) / CLK_NS;

  logic tick, win_start, pending, take;

  refresh_timebase #(.INT_CYC(INT_CYC), .ROWS(ROWS)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick_o(tick), .win_start_o(win_start)
  );

  refresh_backlog #(.ROWS(ROWS), .MAX_OWED(MAX_OWED)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .win_start_i(win_start),
    .burst_req_i(burst_mode_i), .take_i(take), .pending_o(pending)
  );

  refresh_engine #(.ROWS(ROWS), .BUSY_CYC(BUSY_CYC)) u_engine (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .gnt_i(ref_gnt_i),
    .req_o(ref_req_o), .busy_o(ref_busy_o), .take_o(take), .row_o(ref_row_o)
  );
endmodule

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int ROWS = 8;
  localparam int INTV = 20;
  localparam int WIN  = ROWS * INTV;
  localparam int BUSY = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_mode = 1'b0;
  logic       gnt = 1'b0;
  logic       req, busy;
  logic [2:0] row;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int rise_cyc = 0;
  logic prev_busy = 1'b0;
  logic seen_rise = 1'b0;
  logic [2:0] last_row = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .ROWS(ROWS), .CLK_NS(20), .RETENTION_NS(3200), .REFRESH_NS(100), .MAX_OWED(3)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .burst_mode_i(burst_mode), .ref_gnt_i(gnt),
    .ref_req_o(req), .ref_busy_o(busy), .ref_row_o(row)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // monitor: rising edges of busy, row sequence (R6), exclusivity (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        rise_cnt++;
        rise_cyc = cyc;
        if (seen_rise) chk(row == 3'(last_row + 1), "R6 row step", row, 3'(last_row + 1));
        last_row  = row;
        seen_rise = 1'b1;
      end
      if (req && busy) chk(1'b0, "R9 req with busy", 1, 0);
      prev_busy = busy;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_pos(input int p);
    do step(); while ((cyc % WIN) != p);
  endtask

  task automatic t_reset();
    #5;
    chk(req == 1'b0 && busy == 1'b0, "R1 outputs in reset", {req, busy}, 0);
    chk(row == 3'd0, "R1 row in reset", row, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) step();
    chk(req == 1'b0 && busy == 1'b0 && row == 3'd0, "R1 idle after reset", {req, busy, row}, 0);
  endtask

  task automatic t_handshake();
    int n;
    int low;
    while (!req) step();
    low = 0;
    repeat (3) begin step(); if (!req) low++; end
    chk(low == 0, "R4 req held without grant", low, 0);
    gnt = 1'b1;
    step();
    chk(req == 1'b0, "R3 req drops after grant", req, 0);
    chk(busy == 1'b1, "R3 busy after grant", busy, 1);
    gnt = 1'b0;
    n = 0;
    while (busy && n < 50) begin n++; step(); end
    chk(n == BUSY, "R3 busy length", n, BUSY);
  endtask

  task automatic t_backlog();
    int low;
    int r0;
    while (!req) step();
    low = 0;
    repeat (200) begin step(); if (!req) low++; end
    chk(low == 0, "R4 req held for ten intervals", low, 0);
    do step(); while ((cyc % INTV) != 0);
    r0 = rise_cnt;
    gnt = 1'b1;
    repeat (19) step();
    chk(rise_cnt - r0 == 3, "R5 capped catch-up back to back", rise_cnt - r0, 3);
    repeat (41) step();
    chk(rise_cnt - r0 == 5, "R5 no refresh beyond cap", rise_cnt - r0, 5);
  endtask

  task automatic t_distributed();
    int r;
    int last;
    int bad;
    r = rise_cnt;
    while (rise_cnt == r) step();
    last = rise_cyc;
    bad = 0;
    repeat (9) begin
      r = rise_cnt;
      while (rise_cnt == r) step();
      if (rise_cyc - last != INTV) bad++;
      last = rise_cyc;
    end
    chk(bad == 0, "R2 interval spacing", bad, 0);
  endtask

  task automatic t_mode_burst();
    int r0;
    wait_pos(80);
    burst_mode = 1'b1;
    r0 = rise_cnt;
    wait_pos(WIN - 1);
    chk(rise_cnt - r0 == 4, "R8 mid-window switch deferred", rise_cnt - r0, 4);
    r0 = rise_cnt;
    wait_pos(60);
    chk(rise_cnt - r0 == ROWS, "R7 burst of all rows", rise_cnt - r0, ROWS);
    r0 = rise_cnt;
    wait_pos(WIN - 1);
    chk(rise_cnt - r0 == 0, "R7 quiet after burst", rise_cnt - r0, 0);
    r0 = rise_cnt;
    wait_pos(60);
    chk(rise_cnt - r0 == ROWS, "R7 burst repeats next window", rise_cnt - r0, ROWS);
    wait_pos(80);
    burst_mode = 1'b0;
    r0 = rise_cnt;
    wait_pos(WIN - 1);
    chk(rise_cnt - r0 == 0, "R8 burst window kept after switch", rise_cnt - r0, 0);
    r0 = rise_cnt;
    wait_pos(60);
    chk(rise_cnt - r0 == 2, "R8 distributed resumes at boundary", rise_cnt - r0, 2);
  endtask

  initial begin
    t_reset();
    t_handshake();
    t_backlog();
    t_distributed();
    t_mode_burst();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule